// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns parallel words into asynchronous NRZ frames on one output line. Each frame is a low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. When no frame is being sent, the line rests high. Every bit lasts a fixed number of pulses of an oversampling enable, which an external rate generator supplies. By default that number is 16.

A write port loads a one-word holding register. The holding register hands its word to a shift register as soon as the shifter is free. Software can therefore queue the next word while the current frame is still on the line. Two flags report progress, and each flag drives its own gated interrupt request. The first flag, buffer-empty, means the holding register can take a new word. The second, end-of-transmission, means the line has gone idle with nothing queued. A transmit enable stops the line at once.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line output is 1, and both the buffer-empty flag and the end-of-transmission flag are 1.
- R2: A frame is sent as one start bit (0), then the data bits with the least significant bit first, then one stop bit (1). Each bit holds for exactly OSR pulses of `tick16`. The start bit appears in the cycle after the word moves into the shifter.
- R3: The mode input `word9`, sampled at the write, selects the word length: 0 gives 8 data bits and 1 gives 9 data bits. In 9-bit mode the ninth bit is `wr_bit8`, which is also sampled at the write.
- R4: In the cycle after a write, both the buffer-empty flag and the end-of-transmission flag are 0.
- R5: The buffer-empty flag becomes 1 on the clock edge that moves the held word into the shifter. When the transmitter is enabled and idle, that edge is the one right after the write.
- R6: If a word is waiting when a stop bit ends, the start bit of that word follows the stop bit directly, with no idle time between them.
- R7: The end-of-transmission flag becomes 1 on the edge that ends a stop bit, provided no word is waiting at that edge.
- R8: While `tx_en` is 0, the line is 1 from the next cycle on and any frame in progress is abandoned. A word written while `tx_en` is 0 stays held, so the buffer-empty flag stays 0. That word is sent in full once `tx_en` returns to 1.
- R9: `irq_empty` equals the buffer-empty flag AND `ie_empty`, and `irq_done` equals the end-of-transmission flag AND `ie_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable from the rate generator |
| tx_en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Data word to send |
| wr_bit8 | input | 1 | Ninth data bit, used in 9-bit mode |
| word9 | input | 1 | Word length select: 0 for 8 bits, 1 for 9 bits |
| ie_empty | input | 1 | Interrupt enable for buffer-empty |
| ie_done | input | 1 | Interrupt enable for end-of-transmission |
| txd | output | 1 | Serial line output |
| buf_empty | output | 1 | Holding register can accept a word |
| tx_done | output | 1 | Line idle with nothing queued |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | End-of-transmission interrupt request |

## Verification
Single words written to an idle transmitter check the frame layout and the load timing on their own. Pairs of words, where the second is written as soon as the first moves into the shifter, show whether the second start bit follows the first stop bit directly. They also show that end-of-transmission stays low until the queue is empty. Random data is sent in both word lengths and with random ninth bits, together with the all-ones and all-zeros corner words. This separates a wrong bit order or a wrong length from a wrong stop bit. The oversampling enable arrives irregularly, so any bit timing that counts clocks instead of enable pulses shows up. A frame cut off by the enable, followed by a word queued while disabled, tells abandoning a frame apart from resuming it.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          tx_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_bit8,
  input  logic          word9,
  input  logic          ie_empty,
  input  logic          ie_done,
  output logic          txd,
  output logic          buf_empty,
  output logic          tx_done,
  output logic          irq_empty,
  output logic          irq_done
);
  localparam int FW = DW + 3;
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(FW + 1);

  logic [DW-1:0] hold_data;
  logic          hold_b8, hold_m9;
  logic          busy;
  logic [FW-1:0] sh;
  logic [CW-1:0] sub;
  logic [BW-1:0] bitn, last;

  wire bit_end   = busy && tick16 && (sub == CW'(OSR - 1));
  wire frame_end = tx_en && bit_end && (bitn == last);
  wire load      = tx_en && !buf_empty && (!busy || frame_end);

  assign txd       = ~busy | sh[0];
  assign irq_empty = buf_empty & ie_empty;
  assign irq_done  = tx_done & ie_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_b8   <= 1'b0;
      hold_m9   <= 1'b0;
      buf_empty <= 1'b1;
      tx_done   <= 1'b1;
      busy      <= 1'b0;
      sh        <= '1;
      sub       <= '0;
      bitn      <= '0;
      last      <= '0;
    end else begin
      if (wr_en) begin
        hold_data <= wr_data;
        hold_b8   <= wr_bit8;
        hold_m9   <= word9;
      end
      buf_empty <= wr_en ? 1'b0 : (load ? 1'b1 : buf_empty);
      tx_done   <= wr_en ? 1'b0 : ((frame_end && !load) ? 1'b1 : tx_done);
      if (!tx_en) begin
        busy <= 1'b0;
        sub  <= '0;
        bitn <= '0;
      end else if (load) begin
        sh   <= {1'b1, (hold_m9 ? hold_b8 : 1'b1), hold_data, 1'b0};
        busy <= 1'b1;
        sub  <= '0;
        bitn <= '0;
        last <= hold_m9 ? BW'(DW + 2) : BW'(DW + 1);
      end else if (frame_end) begin
        busy <= 1'b0;
      end else if (busy && tick16) begin
        if (bit_end) begin
          sub  <= '0;
          bitn <= bitn + 1'b1;
          sh   <= {1'b1, sh[FW-1:1]};
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  assert_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_hold_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_en && !tick16) |=> $stable(txd));
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!buf_empty && !tx_done));
  assert_empty_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> buf_empty);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !busy);
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done |-> tx_done) and (irq_empty |-> buf_empty));
endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb_top;
  logic clk = 0, rst_n = 0, tick16 = 0, tx_en = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic wr_bit8 = 0, word9 = 0, ie_empty = 0, ie_done = 0;
  logic txd, buf_empty, tx_done, irq_empty, irq_done;
  int vectors = 0, fails = 0;
  int unsigned tick_count = 0;
  int tick_pct = 60;

  always #10 clk = ~clk;

  serial_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .word9(word9), .ie_empty(ie_empty),
    .ie_done(ie_done), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
    .irq_empty(irq_empty), .irq_done(irq_done));

  always @(posedge clk) if (tick16) tick_count <= tick_count + 1;
  always @(negedge clk) tick16 <= (($urandom % 100) < tick_pct);

  function automatic logic exp_bit(input [7:0] d, input b8, input m9, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9) return m9 ? b8 : 1'b1;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input [7:0] d, input b8, input m9, input bit idle);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_bit8 = b8; word9 = m9;
    @(negedge clk);
    wr_en = 0; wr_data = $urandom; wr_bit8 = $urandom; word9 = $urandom;
    chk(!buf_empty && !tx_done, "R4 flags after write", {buf_empty, tx_done}, 0);
    if (idle) begin
      @(negedge clk);
      chk(buf_empty && !txd, "R5 load on next edge", {buf_empty, txd}, 2);
    end
  endtask

  task automatic rx(input [7:0] d, input b8, input m9, input bit last_one);
    int unsigned t0;
    int nb = m9 ? 11 : 10;
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_count;
    for (int k = 0; k < nb; k++) begin
      while (tick_count - t0 < 16 * k + 8) @(negedge clk);
      chk(txd == exp_bit(d, b8, m9, k), m9 ? "R2 R3 frame bit (9-bit)" : "R2 R3 frame bit (8-bit)",
          txd, exp_bit(d, b8, m9, k));
    end
    while (tick_count - t0 < 16 * nb - 1) @(negedge clk);
    chk(txd == 1'b1, "R2 stop bit length", txd, 1);
    while (tick_count - t0 < 16 * nb) @(negedge clk);
    if (last_one)
      chk(tx_done && txd, "R7 done after stop", {tx_done, txd}, 3);
    else
      chk(!tx_done && !txd, "R6 next start follows stop", {tx_done, txd}, 0);
  endtask

  task automatic pair(input [7:0] a, input ab, input [7:0] b, input bb, input m9);
    put(a, ab, m9, 1);
    fork
      begin rx(a, ab, m9, 0); rx(b, bb, m9, 1); end
      begin
        while (!buf_empty) @(negedge clk);
        put(b, bb, m9, 0);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd && buf_empty && tx_done, "R1 reset state", {txd, buf_empty, tx_done}, 7);
    ie_empty = 1; ie_done = 0;
    @(negedge clk);
    chk(irq_empty && !irq_done, "R9 irq gating", {irq_empty, irq_done}, 2);
    tx_en = 1;
    put(8'hFF, 1'b0, 1'b1, 1); rx(8'hFF, 1'b0, 1'b1, 1);
    put(8'h00, 1'b1, 1'b1, 1); rx(8'h00, 1'b1, 1'b1, 1);
    put(8'h00, 1'b0, 1'b0, 1); rx(8'h00, 1'b0, 1'b0, 1);
    ie_done = 1; ie_empty = 0;
    @(negedge clk);
    chk(irq_done && !irq_empty, "R9 irq gating", {irq_empty, irq_done}, 1);
    pair(8'hA5, 1'b1, 8'h3C, 1'b0, 1'b1);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a = $urandom, b = $urandom;
      logic ab = $urandom, bb = $urandom, m = $urandom;
      tick_pct = 30 + ($urandom % 70);
      if ($urandom % 2) pair(a, ab, b, bb, m);
      else begin put(a, ab, m, 1); rx(a, ab, m, 1); end
      ie_empty = $urandom; ie_done = $urandom;
      @(negedge clk);
      chk(irq_empty == (buf_empty & ie_empty) && irq_done == (tx_done & ie_done),
          "R9 irq gating", {irq_empty, irq_done}, {buf_empty & ie_empty, tx_done & ie_done});
    end
    tick_pct = 60;
    put(8'h55, 1'b0, 1'b0, 1);
    repeat (60) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    chk(txd == 1'b1, "R8 line high when disabled", txd, 1);
    put(8'hC3, 1'b1, 1'b1, 0);
    repeat (40) begin
      @(negedge clk);
      if (!(txd && !buf_empty && !tx_done))
        chk(0, "R8 held while disabled", {txd, buf_empty, tx_done}, 4);
    end
    chk(txd && !buf_empty && !tx_done, "R8 held while disabled", {txd, buf_empty, tx_done}, 4);
    tx_en = 1;
    rx(8'hC3, 1'b1, 1'b1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule